// File: doc/BRIEF.md
# Delayed Boot-to-SRAM Window Switch

This block selects which memory answers accesses to a cartridge ROM address window. After reset every access in the window reaches a bootstrap ROM. Software then writes into the window to request the switch. The window does not change on that write. The block waits until a chosen number of further window accesses have completed, and only then hands the window to an SRAM. The wait lets the CPU finish the write, fetch a jump instruction from the boot ROM and execute it before the SRAM appears. The decision is made in logic that follows the bus strobes. No polling software is involved, because the bus runs at about 20 MHz.

The state sits in a four-stage shift chain. The system clock samples the bus strobes. Each completed ROM-window access is detected when the window chip enable returns high. A qualifying write preloads the chain with a thermometer pattern, and the delay input sets how many stages that pattern fills. After that, each completed access shifts a 1 in at the bottom of the chain. The last stage selects the SRAM. The system reset clears the chain asynchronously, and the SRAM enable is forced inactive for as long as reset is held.

Top module: `boot_overlay_switch`

## Requirements
- R1: While reset is held, the chain clears at once. After reset, each access with `win_ce_n` low asserts `boot_ce_n` low and leaves `sram_ce_n` high.
- R2: `sram_ce_n` stays high whenever `sys_rst_n` is low, whatever the internal state.
- R3: Read-only accesses (the write strobe stays high for the whole access) never move the window away from the boot ROM, however many occur.
- R4: A write is an access during which `wr_lo_n` is sampled low while `win_ce_n` is low and `wr_data` is 1. Such a write arms the switch. Byte and half-word writes assert the same low-byte strobe, and each counts as one access. The write access itself is served by the boot ROM.
- R5: With `delay_sel` = d (0 to 3), captured at the arming write, the boot ROM also serves the next d+1 accesses after that write. Every later access is served by the SRAM.
- R6: A write with `wr_data` = 0 is ignored. It neither arms the switch nor restarts the count.
- R7: Once the SRAM owns the window, it keeps it until the next reset. Further writes have no effect.
- R8: A qualifying write that arrives before the swap restarts the count, using the delay value presented with that write.
- R9: `boot_ce_n` and `sram_ce_n` are never low together. Each can be low only while `win_ce_n` is low.
- R10: Clock cycles with `win_ce_n` high do not advance the count. Only completed accesses do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus strobes |
| sys_rst_n | input | 1 | Active-low system reset, asynchronous assertion |
| win_ce_n | input | 1 | Active-low chip enable of the ROM address window |
| wr_lo_n | input | 1 | Active-low low-byte write strobe |
| wr_data | input | 1 | Data bus bit sampled with a write; 1 requests the switch |
| delay_sel | input | 2 | Number of extra boot accesses after the write, minus one |
| boot_ce_n | output | 1 | Active-low chip enable of the bootstrap ROM |
| sram_ce_n | output | 1 | Active-low chip enable of the SRAM |

## Verification
Each of the four delay settings gets its own sequence. A write is followed by a run of reads, and the bench finds the exact access on which the window changes owner, so an off-by-one error in the preload pattern shows up at once. Long runs of reads with no write, and writes carrying a data bit of 0, separate a correct arming condition from one that shifts on every access. A second write before the swap, a write after the swap, and a reset applied while the SRAM owns the window test the restart, the one-way latch and the reset forcing of the SRAM enable. Idle gaps between accesses show that only completed accesses move the count.

// File: rtl/boot_overlay_pkg.sv
package boot_overlay_pkg;

  // One completed window access, reported in the cycle its end is seen.
  typedef struct packed {
    logic acc_done;   // win_ce_n returned high this cycle
    logic was_write;  // low-byte strobe seen during the access
    logic wr_bit;     // data bit captured with the strobe
  } acc_evt_t;

endpackage

// File: rtl/ovl_access_mon.sv
module ovl_access_mon
  import boot_overlay_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     win_ce_n,
  input  logic     wr_lo_n,
  input  logic     wr_data,
  output acc_evt_t evt
);

  logic ce_q, ce_d;
  logic wr_seen_q, wr_seen_d;
  logic bit_q, bit_d;
  logic done;

  assign done = win_ce_n & ~ce_q;

  always_comb begin
    ce_d      = win_ce_n;
    wr_seen_d = wr_seen_q;
    bit_d     = bit_q;
    if (done) begin
      wr_seen_d = 1'b0;
      bit_d     = 1'b0;
    end else if (!win_ce_n && !wr_lo_n) begin
      wr_seen_d = 1'b1;
      bit_d     = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q      <= 1'b1;
      wr_seen_q <= 1'b0;
      bit_q     <= 1'b0;
    end else begin
      ce_q      <= ce_d;
      wr_seen_q <= wr_seen_d;
      bit_q     <= bit_d;
    end
  end

  assign evt.acc_done  = done;
  assign evt.was_write = wr_seen_q;
  assign evt.wr_bit    = bit_q;

  // R4: a strobe inside an access is remembered until that access ends
  assert_strobe_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_ce_n && !wr_lo_n) |=> (wr_seen_q || win_ce_n));

endmodule

// File: rtl/ovl_shift_chain.sv
module ovl_shift_chain
  import boot_overlay_pkg::*;
#(
  parameter int DEPTH        = 4,
  parameter int DLY_W        = $clog2(DEPTH),
  parameter bit USE_DATA_BIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  acc_evt_t         evt,
  input  logic [DLY_W-1:0] dly,
  output logic             sel_sram
);

  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] stage_q, stage_d, preload;
  logic             armed_q, armed_d;
  logic             load_en, shift_en, req_ok;

  assign req_ok   = USE_DATA_BIT ? evt.wr_bit : 1'b1;
  assign load_en  = evt.acc_done & evt.was_write & req_ok & ~stage_q[LAST];
  assign shift_en = evt.acc_done & ~load_en & armed_q;

  // Thermometer preload: the stages below DEPTH-1-dly start at 1.
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    assign preload[i] = (i + int'(dly)) <= (DEPTH - 2);
    if (i == 0) begin : g_head
      assign stage_d[i] = load_en ? preload[i] : (shift_en ? 1'b1 : stage_q[i]);
    end else begin : g_body
      assign stage_d[i] = load_en ? preload[i] : (shift_en ? stage_q[i-1] : stage_q[i]);
    end
  end

  always_comb begin
    armed_d = armed_q | load_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      armed_q <= 1'b0;
    end else begin
      stage_q <= stage_d;
      armed_q <= armed_d;
    end
  end

  assign sel_sram = stage_q[LAST];

  // R7: the swap is one-way until reset
  assert_swap_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stage_q[LAST] |=> stage_q[LAST]);
  // R10: without a completed access the chain holds
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.acc_done |=> $stable(stage_q));
  // R3: no swap before a write has armed the chain
  assert_unarmed_boot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !stage_q[LAST]);
  // R5: a shift always enters a 1 at the head
  assert_head_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> stage_q[0]);

endmodule

// File: rtl/ovl_window_gate.sv
module ovl_window_gate (
  input  logic clk,
  input  logic rst_raw_n,
  input  logic rst_sync_n,
  input  logic win_ce_n,
  input  logic sel_sram,
  output logic boot_ce_n,
  output logic sram_ce_n
);

  logic in_reset;

  assign in_reset  = ~rst_raw_n | ~rst_sync_n;
  assign boot_ce_n = win_ce_n | sel_sram;
  assign sram_ce_n = win_ce_n | ~sel_sram | in_reset;

  // R9: never both memories at once
  assert_no_overlap_R9: assert property (@(posedge clk)
    boot_ce_n || sram_ce_n);
  // R9: nothing enabled outside an access
  assert_idle_quiet_R9: assert property (@(posedge clk)
    win_ce_n |-> (boot_ce_n && sram_ce_n));
  // R2: SRAM kept off during reset
  assert_sram_off_rst_R2: assert property (@(posedge clk)
    !rst_raw_n |-> sram_ce_n);

endmodule

// File: rtl/boot_overlay_switch.sv
module boot_overlay_switch
  import boot_overlay_pkg::*;
#(
  parameter int DEPTH        = 4,
  parameter int DLY_W        = $clog2(DEPTH),
  parameter bit USE_DATA_BIT = 1'b1
) (
  input  logic             clk,
  input  logic             sys_rst_n,
  input  logic             win_ce_n,
  input  logic             wr_lo_n,
  input  logic             wr_data,
  input  logic [DLY_W-1:0] delay_sel,
  output logic             boot_ce_n,
  output logic             sram_ce_n
);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       sel_sram;
  acc_evt_t   evt;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) rst_pipe_q <= 2'b00;
    else            rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  ovl_access_mon u_mon (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .win_ce_n (win_ce_n),
    .wr_lo_n  (wr_lo_n),
    .wr_data  (wr_data),
    .evt      (evt)
  );

  ovl_shift_chain #(
    .DEPTH        (DEPTH),
    .DLY_W        (DLY_W),
    .USE_DATA_BIT (USE_DATA_BIT)
  ) u_chain (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt      (evt),
    .dly      (delay_sel),
    .sel_sram (sel_sram)
  );

  ovl_window_gate u_gate (
    .clk        (clk),
    .rst_raw_n  (sys_rst_n),
    .rst_sync_n (rst_sync_n),
    .win_ce_n   (win_ce_n),
    .sel_sram   (sel_sram),
    .boot_ce_n  (boot_ce_n),
    .sram_ce_n  (sram_ce_n)
  );

endmodule

// File: tb/boot_overlay_switch_tb.sv
module boot_overlay_switch_tb_top;

  logic       clk = 1'b0;
  logic       sys_rst_n, win_ce_n, wr_lo_n, wr_data;
  logic [1:0] delay_sel;
  logic       boot_ce_n, sram_ce_n;

  always #2 clk = ~clk;

  boot_overlay_switch dut_i (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .win_ce_n  (win_ce_n),
    .wr_lo_n   (wr_lo_n),
    .wr_data   (wr_data),
    .delay_sel (delay_sel),
    .boot_ce_n (boot_ce_n),
    .sram_ce_n (sram_ce_n)
  );

  int checks = 0, errors = 0, overlap_bad = 0;
  bit done = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  // reference model
  bit m_swapped, m_armed;
  int m_left;

  task automatic model_reset();
    m_swapped = 0; m_armed = 0; m_left = 0;
  endtask

  // one window access; expected {boot_ce_n, sram_ce_n} is pushed
  task automatic access(input bit is_wr, input bit dat, input logic [1:0] d,
                        input string tag, input int gap);
    @(negedge clk);
    delay_sel = d; wr_data = dat; win_ce_n = 1'b0;
    exp_q.push_back(m_swapped ? 2'b10 : 2'b01);
    tag_q.push_back(tag);
    @(negedge clk); if (is_wr) wr_lo_n = 1'b0;
    @(negedge clk); wr_lo_n = 1'b1;
    @(negedge clk); win_ce_n = 1'b1;
    if (!m_swapped && is_wr && dat) begin
      m_armed = 1; m_left = int'(d) + 1;
    end else if (m_armed && !m_swapped) begin
      m_left--; if (m_left == 0) m_swapped = 1;
    end
    repeat (gap) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); sys_rst_n = 1'b0;
    model_reset();
    access(0, 0, 2'd0, "R1/R2 in reset", 1);
    @(negedge clk); sys_rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // monitor: compare each access against the scoreboard
  initial begin
    forever begin
      @(negedge win_ce_n);
      #1;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected access: actual=%b%b expected=none", boot_ce_n, sram_ce_n);
      end else begin
        logic [1:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if ({boot_ce_n, sram_ce_n} !== e) begin
          errors++;
          $display("FAIL %s: actual=%b%b expected=%b", t, boot_ce_n, sram_ce_n, e);
        end
        if (!sys_rst_n) begin // R2 with the SRAM chain state forced
          checks++;
          if (sram_ce_n !== 1'b1) begin
            errors++;
            $display("FAIL R2: actual sram_ce_n=%b expected=1", sram_ce_n);
          end
        end
      end
    end
  end

  // R9 overlap and idle watch
  initial begin
    forever begin
      @(negedge clk); #1;
      if ((!boot_ce_n && !sram_ce_n) || (win_ce_n === 1'b1 && (!boot_ce_n || !sram_ce_n)))
        overlap_bad++;
    end
  end

  task automatic finish_run();
    checks++;
    if (overlap_bad != 0) begin
      errors++;
      $display("FAIL R9: actual bad cycles=%0d expected=0", overlap_bad);
    end
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual pending=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    sys_rst_n = 1'b0; win_ce_n = 1'b1; wr_lo_n = 1'b1; wr_data = 1'b0; delay_sel = 2'd0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state with outputs idle
    checks++;
    if (boot_ce_n !== 1'b1 || sram_ce_n !== 1'b1) begin
      errors++;
      $display("FAIL R1 idle: actual=%b%b expected=11", boot_ce_n, sram_ce_n);
    end
    do_reset();

    // R3: many reads, never swap
    for (int i = 0; i < 8; i++) access(0, 0, 2'd0, "R3 reads only", 1);
    // R6: write with data bit 0 ignored
    access(1, 0, 2'd0, "R6 write data=0", 1);
    for (int i = 0; i < 3; i++) access(0, 0, 2'd0, "R6 after ignored write", 1);

    // R4/R5: each delay setting, with varied idle gaps (R10)
    for (int d = 0; d < 4; d++) begin
      do_reset();
      access(0, 0, 2'(d), "R1 boot after reset", 2);
      access(1, 1, 2'(d), "R4 write served by boot", 5);
      for (int k = 0; k < d + 3; k++) access(0, 0, 2'd3, "R5 delay count", k * 3);
    end

    // R7: writes after the swap, then R1/R2 reset out of the swapped state
    access(1, 1, 2'd3, "R7 write after swap", 1);
    access(0, 0, 2'd0, "R7 still SRAM", 1);
    do_reset();
    access(0, 0, 2'd0, "R1 boot after swap reset", 1);

    // R8: reload before the swap with a shorter delay
    access(1, 1, 2'd3, "R8 first write", 1);
    access(0, 0, 2'd0, "R8 one read", 1);
    access(1, 1, 2'd0, "R8 reload write", 1);
    for (int k = 0; k < 3; k++) access(0, 0, 2'd0, "R8 restarted count", 1);
    // half-word style write uses the same strobe: treat as R4 after reset
    do_reset();
    access(1, 1, 2'd1, "R4 half-word write", 20);
    for (int k = 0; k < 4; k++) access(0, 0, 2'd0, "R4 R10 gap count", 1);

    repeat (4) @(negedge clk);
    done = 1;
    finish_run();
  end

endmodule